// File: doc/BRIEF.md
# Shadow Window Bank Controller

This block sits between an 8-bit CPU bus and a host mainboard. It lets a fixed window of the CPU memory map be served by an add-on RAM instead of main RAM. Two one-bit control flags live in a small I/O page. A shadow flag turns the window on. A memory-select flag overrides it and keeps the window on main RAM.

Both flags are loaded at the falling edge of the CPU's second clock phase, which is where the bus cycle ends. The load uses an enable that combines the write strobe and the address decode. No clock is ever derived from logic. While the window is active, three things happen:
- the add-on RAM enable is driven;
- the mainboard's clock phase is held high;
- the mainboard's read/write strobe is held at read, so main RAM underneath the window is never written.

Top module: `shadow_bank_ctrl`

## Requirements
- R1: A write (cpu_rnw = 0) to any address from 0xFE34 to 0xFE37 copies data bit 7 into the shadow flag at the falling edge of phi2. That range is address bits 15:4 equal to 0xFE3 and bits 3:2 equal to 01. The other data bits have no effect.
- R2: A write to any address from 0xFE30 to 0xFE33 (bits 3:2 equal to 00) copies data bit 7 into the memory-select flag at the falling edge of phi2. While that flag is 1, the window is never active.
- R3: rst_n low clears both flags at once, without waiting for a clock edge. After reset the window is inactive and all outputs pass through.
- R4: The window is active exactly when the address lies in 0x3000 to 0x7FFF, the shadow flag is 1 and the memory-select flag is 0. While it is active, ram_ce is 1; otherwise ram_ce is 0.
- R5: board_phi1 equals phi1 while the window is inactive and is 1 while it is active.
- R6: board_rnw equals cpu_rnw while the window is inactive and is 1 (read) while it is active, including during CPU writes into the window.
- R7: Writing 0 in bit 7 to 0xFE34 clears the shadow flag whatever addresses the CPU used before, including directly after accesses inside the window.
- R8: Accesses from 0x0000 to 0x2FFF and from 0x8000 upward never drive ram_ce, whatever the flag values.
- R9: The flags do not change on reads of 0xFE30 to 0xFE37, nor on writes to 0xFE38 and above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| phi2 | input | 1 | CPU second clock phase; flags load on its falling edge |
| phi1 | input | 1 | CPU first clock phase, forwarded to the mainboard |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 16 | CPU address bus |
| wdata | input | 8 | CPU data bus as seen during writes |
| cpu_rnw | input | 1 | CPU read/write strobe, 1 = read |
| board_phi1 | output | 1 | Clock phase sent to the mainboard |
| board_rnw | output | 1 | Read/write strobe sent to the mainboard |
| ram_ce | output | 1 | Add-on RAM enable, active high |

## Verification
The hardest case to reach is R7. A control write must clear the shadow flag right after the CPU has been working inside the active window. It must do so while the mainboard strobes are still held, and it must leave the window on main RAM. The bench reaches this case directly: it switches the window on, runs reads and writes at its lower and upper edges, then writes 0x7F to 0xFE37. The next window access must fall back to main RAM. Random cycles with a fixed seed then aim most addresses at the control page, the window edges and the bytes just outside it. This mixes flag loads, reads of the control page and accesses to unused I/O addresses.

// File: rtl/shadow_bank_pkg.sv
package shadow_bank_pkg;

    localparam int BUS_AW = 16;
    localparam int BUS_DW = 8;
    localparam int PAGE_W = BUS_AW - 4;

    typedef enum logic [1:0] {
        SLOT_NONE   = 2'd0,
        SLOT_MEMSEL = 2'd1,
        SLOT_SHADOW = 2'd2
    } ctrl_slot_e;

    typedef struct packed {
        logic shadow_en;
        logic mem_sel;
    } ctrl_flags_t;

    // numeric field compares on the page and the two-bit slot
    function automatic ctrl_slot_e decode_slot(input logic [BUS_AW-1:0] a,
                                               input logic [PAGE_W-1:0] page);
        ctrl_slot_e s;
        s = SLOT_NONE;
        if (a[BUS_AW-1:4] == page) begin
            if (a[3:2] == 2'b00)      s = SLOT_MEMSEL;
            else if (a[3:2] == 2'b01) s = SLOT_SHADOW;
        end
        return s;
    endfunction

    function automatic logic in_window(input logic [BUS_AW-1:0] a,
                                       input logic [BUS_AW-1:0] first,
                                       input logic [BUS_AW-1:0] last);
        return (a >= first) && (a <= last);
    endfunction

endpackage

// File: rtl/shadow_ctrl_regs.sv
module shadow_ctrl_regs
    import shadow_bank_pkg::*;
#(
    parameter logic [PAGE_W-1:0] IO_PAGE  = 12'hFE3,
    parameter int                FLAG_BIT = 7
) (
    input  logic              phi2,
    input  logic              rst_n,
    input  logic [BUS_AW-1:0] addr,
    input  logic              flag_data,
    input  logic              cpu_rnw,
    output ctrl_flags_t       flags
);

    ctrl_slot_e slot;
    logic       ld_shadow;
    logic       ld_memsel;

    always_comb begin
        slot      = decode_slot(addr, IO_PAGE);
        ld_shadow = !cpu_rnw && (slot == SLOT_SHADOW);
        ld_memsel = !cpu_rnw && (slot == SLOT_MEMSEL);
    end

    // end of bus cycle, qualified by an enable rather than a gated clock
    always_ff @(negedge phi2 or negedge rst_n) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            if (ld_shadow) flags.shadow_en <= flag_data;
            if (ld_memsel) flags.mem_sel   <= flag_data;
        end
    end

    assert_shadow_load_R1: assert property (@(negedge phi2) disable iff (!rst_n)
        ld_shadow |=> (flags.shadow_en == $past(flag_data)));

    assert_memsel_load_R2: assert property (@(negedge phi2) disable iff (!rst_n)
        ld_memsel |=> (flags.mem_sel == $past(flag_data)));

    assert_read_quiet_R9: assert property (@(negedge phi2) disable iff (!rst_n)
        cpu_rnw |=> ($stable(flags.shadow_en) && $stable(flags.mem_sel)));

endmodule

// File: rtl/shadow_window_dec.sv
module shadow_window_dec
    import shadow_bank_pkg::*;
#(
    parameter logic [BUS_AW-1:0] WIN_FIRST = 16'h3000,
    parameter logic [BUS_AW-1:0] WIN_LAST  = 16'h7FFF
) (
    input  logic [BUS_AW-1:0] addr,
    input  ctrl_flags_t       flags,
    output logic              win_active
);

    logic hit;

    always_comb begin
        hit        = in_window(addr, WIN_FIRST, WIN_LAST);
        win_active = hit && flags.shadow_en && !flags.mem_sel;
    end

endmodule

// File: rtl/shadow_bus_gate.sv
module shadow_bus_gate #(
    parameter bit CE_ACTIVE_HIGH = 1'b1
) (
    input  logic phi2,
    input  logic rst_n,
    input  logic phi1,
    input  logic cpu_rnw,
    input  logic win_active,
    output logic board_phi1,
    output logic board_rnw,
    output logic ram_ce
);

    always_comb begin
        board_phi1 = win_active ? 1'b1 : phi1;
        board_rnw  = win_active ? 1'b1 : cpu_rnw;
    end

    generate
        if (CE_ACTIVE_HIGH) begin : g_ce_high
            assign ram_ce = win_active;
        end else begin : g_ce_low
            assign ram_ce = !win_active;
        end
    endgenerate

    assert_board_held_R6: assert property (@(posedge phi2) disable iff (!rst_n)
        win_active |-> (board_rnw && board_phi1));

    assert_board_pass_R5: assert property (@(posedge phi2) disable iff (!rst_n)
        !win_active |-> ((board_phi1 == phi1) && (board_rnw == cpu_rnw)));

endmodule

// File: rtl/shadow_bank_ctrl.sv
module shadow_bank_ctrl
    import shadow_bank_pkg::*;
#(
    parameter logic [PAGE_W-1:0] IO_PAGE   = 12'hFE3,
    parameter int                FLAG_BIT  = 7,
    parameter logic [BUS_AW-1:0] WIN_FIRST = 16'h3000,
    parameter logic [BUS_AW-1:0] WIN_LAST  = 16'h7FFF
) (
    input  logic              phi2,
    input  logic              phi1,
    input  logic              rst_n,
    input  logic [BUS_AW-1:0] addr,
    input  logic [BUS_DW-1:0] wdata,
    input  logic              cpu_rnw,
    output logic              board_phi1,
    output logic              board_rnw,
    output logic              ram_ce
);

    ctrl_flags_t flags;
    logic        win_active;
    logic        unused_data_bits;

    assign unused_data_bits = ^wdata;

    shadow_ctrl_regs #(
        .IO_PAGE (IO_PAGE),
        .FLAG_BIT(FLAG_BIT)
    ) i_regs (
        .phi2     (phi2),
        .rst_n    (rst_n),
        .addr     (addr),
        .flag_data(wdata[FLAG_BIT]),
        .cpu_rnw  (cpu_rnw),
        .flags    (flags)
    );

    shadow_window_dec #(
        .WIN_FIRST(WIN_FIRST),
        .WIN_LAST (WIN_LAST)
    ) i_dec (
        .addr      (addr),
        .flags     (flags),
        .win_active(win_active)
    );

    shadow_bus_gate #(
        .CE_ACTIVE_HIGH(1'b1)
    ) i_gate (
        .phi2      (phi2),
        .rst_n     (rst_n),
        .phi1      (phi1),
        .cpu_rnw   (cpu_rnw),
        .win_active(win_active),
        .board_phi1(board_phi1),
        .board_rnw (board_rnw),
        .ram_ce    (ram_ce)
    );

    assert_window_only_R4: assert property (@(posedge phi2) disable iff (!rst_n)
        ram_ce |-> ((addr >= WIN_FIRST) && (addr <= WIN_LAST)
                    && flags.shadow_en && !flags.mem_sel));

    assert_outside_quiet_R8: assert property (@(posedge phi2) disable iff (!rst_n)
        ((addr < WIN_FIRST) || (addr > WIN_LAST)) |-> !ram_ce);

endmodule

// File: tb/test_shadow_bank_ctrl.sv
module test_shadow_bank_ctrl;

    logic        phi2 = 1'b0;
    logic        phi1;
    logic        rst_n = 1'b0;
    logic [15:0] addr = 16'h0000;
    logic [7:0]  wdata = 8'h00;
    logic        cpu_rnw = 1'b1;
    logic        board_phi1, board_rnw, ram_ce;

    int checks = 0;
    int errors = 0;
    logic m_sh = 1'b0;
    logic m_ms = 1'b0;

    always #5 phi2 = ~phi2;
    assign phi1 = ~phi2;

    shadow_bank_ctrl i_shadow_bank_ctrl (
        .phi2(phi2), .phi1(phi1), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .cpu_rnw(cpu_rnw), .board_phi1(board_phi1), .board_rnw(board_rnw),
        .ram_ce(ram_ce)
    );

    function automatic logic exp_active(input logic [15:0] a, input logic sh, input logic ms);
        return (a >= 16'h3000) && (a <= 16'h7FFF) && sh && !ms;
    endfunction

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b time=%0t", tag, act, exp, $time);
        end
    endtask

    // one bus cycle: drive after phi2 falls, check in both phases, update model
    task automatic cyc(input logic [15:0] a, input logic [7:0] d, input logic rnw,
                       input string tag);
        logic act;
        @(negedge phi2); #1;
        addr = a; wdata = d; cpu_rnw = rnw;
        act = exp_active(a, m_sh, m_ms);
        #2;
        check({tag, " R4 ram_ce"}, ram_ce, act);
        check({tag, " R6 board_rnw"}, board_rnw, act ? 1'b1 : rnw);
        check({tag, " R5 board_phi1 hi"}, board_phi1, 1'b1);
        @(posedge phi2); #2;
        check({tag, " R5 board_phi1 lo"}, board_phi1, act ? 1'b1 : 1'b0);
        if (!rnw && a[15:4] == 12'hFE3) begin
            if (a[3:2] == 2'b01) m_sh = d[7];
            if (a[3:2] == 2'b00) m_ms = d[7];
        end
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        addr = 16'h3000;
        #13;
        check("R3 reset ram_ce", ram_ce, 1'b0);
        @(negedge phi2); #1; rst_n = 1'b1;

        cyc(16'h3000, 8'h00, 1'b1, "R3 post reset");
        cyc(16'hFE34, 8'h80, 1'b0, "R1 set shadow");
        cyc(16'h3000, 8'h00, 1'b1, "R4 window low");
        cyc(16'h4000, 8'h55, 1'b0, "R6 write in window");
        cyc(16'h2FFF, 8'h00, 1'b0, "R8 below window");
        cyc(16'h8000, 8'h00, 1'b1, "R8 above window");
        cyc(16'hFE34, 8'h00, 1'b1, "R9 read ctrl");
        cyc(16'hFE38, 8'h00, 1'b0, "R9 write FE38");
        cyc(16'h5000, 8'h00, 1'b1, "R9 still active");
        cyc(16'hFE32, 8'h80, 1'b0, "R2 set memsel");
        cyc(16'h5000, 8'h00, 1'b1, "R2 memsel blocks");
        cyc(16'hFE30, 8'h7F, 1'b0, "R2 clear memsel");
        cyc(16'h7FFF, 8'h00, 1'b1, "R4 window high");
        cyc(16'h6000, 8'hAA, 1'b0, "R7 window write");
        cyc(16'hFE37, 8'h7F, 1'b0, "R7 clear from window");
        cyc(16'h6000, 8'h00, 1'b0, "R7 window released");
        cyc(16'hFE35, 8'h80, 1'b0, "R1 set via FE35");
        cyc(16'h3000, 8'h00, 1'b1, "R1 active again");

        // asynchronous reset in the middle of a phase
        @(posedge phi2); #1; rst_n = 1'b0; #1;
        check("R3 async clear ram_ce", ram_ce, 1'b0);
        check("R3 async clear board_rnw", board_rnw, 1'b1);
        m_sh = 1'b0; m_ms = 1'b0;
        @(negedge phi2); #1; rst_n = 1'b1;
        cyc(16'h3000, 8'h00, 1'b0, "R3 after async reset");

        for (int i = 0; i < 400; i++) begin
            logic [15:0] a;
            int sel;
            sel = $urandom_range(0, 5);
            case (sel)
                0: a = 16'hFE30 + 16'($urandom_range(0, 11));
                1: a = 16'h3000 + 16'($urandom_range(0, 3));
                2: a = 16'h7FFC + 16'($urandom_range(0, 3));
                3: a = 16'h2FFE + 16'($urandom_range(0, 1));
                4: a = 16'h8000 + 16'($urandom_range(0, 1));
                default: a = 16'($urandom);
            endcase
            cyc(a, 8'($urandom), 1'($urandom), "R4 random");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule